// File: doc/BRIEF.md
# Ones-Count to Thermometer Converter

The block takes a 16-bit data word together with a one-cycle strobe that marks when the word is valid. It returns a 16-bit code whose number of zero bits equals the number of one bits in the word. The zeros fill the least significant positions and every bit above them is one. Internally the word is split into a low byte and a high byte. Each byte's ones are counted, the two counts are added into a 5-bit total (the carry is kept, so a full word gives 16), and the total is decoded into the thermometer-style output.

The result is captured into an output register on the clock edge that samples the strobe, and it is held until the next strobe. A small down-counter delays the strobe to make a one-cycle ready pulse. The delay is a parameter. It defaults to one clock, which suits the fast arithmetic form at the nominal 5 MHz clock; a slower form can be built with a longer delay. A strobe that arrives while a delay is still running restarts the count, so only the latest word gets a ready pulse.

Top module: `ones_thermo`

## Requirements
- R1: At the rising clock edge where `strobe_i` is high, `code_o` is loaded so that its count of zero bits equals the count of one bits in `data_i`. The two bytes are counted apart and their counts summed with the carry kept.
- R2: The zero bits of `code_o` sit in positions 0 upward with no gap, and every bit above the highest zero is one.
- R3: A `data_i` of all zeros gives a `code_o` of all ones (16'hFFFF).
- R4: A `data_i` of all ones gives a `code_o` of all zeros (16'h0000).
- R5: `code_o` changes only at an edge where `strobe_i` is high. When `data_i` changes without a strobe, `code_o` does not change.
- R6: `ready_o` goes high for exactly one cycle, DELAY cycles after the cycle in which `strobe_i` was high (DELAY=1 means the next cycle), unless a later strobe arrives first.
- R7: A strobe that arrives before the pending ready pulse has appeared restarts the delay. Exactly one ready pulse follows, DELAY cycles after the last strobe, and `code_o` then shows the last word's result.
- R8: Synchronous active-high `rst` sets `code_o` to all ones, drives `ready_o` low and cancels any pending ready pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | One-cycle pulse marking `data_i` as valid |
| data_i | input | 16 | Input word whose ones are counted |
| ready_o | output | 1 | One-cycle pulse saying `code_o` holds the latest result |
| code_o | output | 16 | Thermometer code, zeros in the low positions |

## Verification
The converter is fed all zeros and all ones, which hit the two ends of the 0..16 range and the carry out of the adder. It also gets words whose ones all lie in one byte, so each half counter is tested alone, and words with ones in both bytes, which test the sum. A spread of pseudo-random words covers the remaining totals, each compared against a count done in the bench. A second instance with a three-cycle delay gets back-to-back strobes and a reset in the middle of a delay; these tell a restarted count apart from a doubled or lost ready pulse.

// File: rtl/ones_thermo.sv
module ones_thermo #(
  parameter int WIDTH = 16,
  parameter int DELAY = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             ready_o,
  output logic [WIDTH-1:0] code_o
);
  localparam int HALF = WIDTH / 2;
  localparam int HW   = $clog2(HALF + 1);
  localparam int CW   = $clog2(WIDTH + 1);
  localparam int DW   = $clog2(DELAY + 1);

  logic [HW-1:0]    cnt_lo, cnt_hi;
  logic [CW-1:0]    total;
  logic [WIDTH-1:0] thermo;
  logic [DW-1:0]    wait_q;

  always_comb begin
    cnt_lo = '0;
    cnt_hi = '0;
    for (int i = 0; i < HALF; i++) begin
      cnt_lo = cnt_lo + HW'(data_i[i]);
      cnt_hi = cnt_hi + HW'(data_i[HALF+i]);
    end
  end

  assign total = CW'(cnt_lo) + CW'(cnt_hi);

  for (genvar g = 0; g < WIDTH; g++) begin : g_thermo
    assign thermo[g] = (total <= CW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst)           code_o <= '1;
    else if (strobe_i) code_o <= thermo;
  end

  always_ff @(posedge clk) begin
    if (rst)                wait_q <= '0;
    else if (strobe_i)      wait_q <= DW'(DELAY);
    else if (wait_q != '0)  wait_q <= wait_q - 1'b1;
  end

  assign ready_o = (wait_q == DW'(1));
endmodule

// File: rtl/ones_thermo_chk.sv
module ones_thermo_chk #(
  parameter int WIDTH = 16,
  parameter int DELAY = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe_i,
  input logic [WIDTH-1:0] data_i,
  input logic             ready_o,
  input logic [WIDTH-1:0] code_o
);
  logic [WIDTH-1:0] inv;
  assign inv = ~code_o;

  AST_ONES_MATCH: assert property (@(posedge clk) disable iff (rst)
    strobe_i |=> ($countones(~code_o) == $countones($past(data_i)))); // R1

  AST_THERMO_SHAPE: assert property (@(posedge clk) disable iff (rst)
    ((inv & (inv + WIDTH'(1))) == '0)); // R2

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> $stable(code_o)); // R5

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !strobe_i) |=> !ready_o); // R6

  if (DELAY == 1) begin : g_fast
    AST_READY_NEXT: assert property (@(posedge clk) disable iff (rst)
      strobe_i |=> ready_o); // R6
  end else begin : g_slow
    AST_READY_LATER: assert property (@(posedge clk) disable iff (rst)
      strobe_i |=> !ready_o); // R7
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (code_o == '1 && !ready_o)); // R8
endmodule

bind ones_thermo ones_thermo_chk #(.WIDTH(WIDTH), .DELAY(DELAY)) u_chk (.*);

// File: tb/ones_thermo_tb.sv
module ones_thermo_tb;
  localparam int CLK_PERIOD = 200;
  localparam int SLOW_DELAY = 3;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [15:0] data = '0;
  logic        rdy_f, rdy_s;
  logic [15:0] code_f, code_s;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_cyc = -100;
  bit done = 0;
  logic [15:0] q_fast[$];
  logic [15:0] q_slow[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ones_thermo u_dut (.clk(clk), .rst(rst), .strobe_i(strobe), .data_i(data),
                     .ready_o(rdy_f), .code_o(code_f));
  ones_thermo #(.DELAY(SLOW_DELAY)) u_dut_slow (.clk(clk), .rst(rst), .strobe_i(strobe),
                     .data_i(data), .ready_o(rdy_s), .code_o(code_s));

  function automatic logic [15:0] expect_code(input logic [15:0] x);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(x[i]);
    return 16'hFFFF << n;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one-cycle strobe, expected items into the scoreboard queues
  task automatic send(input logic [15:0] x);
    @(negedge clk);
    q_fast.push_back(expect_code(x));
    if (cyc - last_cyc < SLOW_DELAY && q_slow.size() > 0) void'(q_slow.pop_back()); // R7 restart
    q_slow.push_back(expect_code(x));
    last_cyc = cyc;
    data = x;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitors
  always @(negedge clk) begin
    if (!rst && rdy_f) begin
      if (q_fast.size() == 0) check("R6 fast unexpected ready", 16'd1, 16'd0);
      else check("R1/R6 fast result", code_f, q_fast.pop_front());
    end
    if (!rst && rdy_s) begin
      if (q_slow.size() == 0) check("R7 slow unexpected ready", 16'd1, 16'd0);
      else check("R7 slow result", code_s, q_slow.pop_front());
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R8 reset code", code_f, 16'hFFFF);
    check("R8 reset ready", {15'd0, rdy_f | rdy_s}, 16'd0);
    rst = 1'b0;
    idle(2);

    send(16'h0000); idle(5);
    check("R3 all zeros", code_f, 16'hFFFF);
    send(16'hFFFF); idle(5);
    check("R4 all ones", code_f, 16'h0000);
    send(16'h00FF); idle(5);
    check("R1 low byte only", code_f, 16'hFF00);
    send(16'hF000); idle(5);
    check("R1 high byte only", code_f, 16'hFFF0);
    send(16'h8001); idle(5);
    check("R2 both bytes", code_f, 16'hFFFC);

    // R6: exact ready timing on the fast instance
    @(negedge clk);
    q_fast.push_back(expect_code(16'h0F0F));
    q_slow.push_back(expect_code(16'h0F0F));
    last_cyc = cyc;
    data = 16'h0F0F; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    check("R6 fast ready next cycle", {15'd0, rdy_f}, 16'd1);
    @(negedge clk);
    check("R6 fast ready one wide", {15'd0, rdy_f}, 16'd0);
    idle(5);

    // R5: data change without strobe is ignored
    data = 16'h1234; idle(4);
    check("R5 hold without strobe", code_f, 16'hFF00);
    check("R5 hold without strobe slow", code_s, 16'hFF00);

    for (int k = 0; k < 40; k++) begin
      send(16'($urandom)); idle(5);
    end

    // R7: back-to-back strobes on the slow instance
    send(16'h0003);
    send(16'h7000);
    idle(6);
    check("R7 slow final code", code_s, 16'hFFF8);

    // R8: reset during a pending delay cancels the ready
    send(16'h00F0);
    rst = 1'b1;
    q_slow.delete();
    q_fast.delete();
    idle(2);
    check("R8 reset code", code_s, 16'hFFFF);
    rst = 1'b0;
    idle(6);
    check("R8 no ready after reset", {15'd0, rdy_s}, 16'd0);

    check("R6 fast queue drained", 16'(q_fast.size()), 16'd0);
    check("R7 slow queue drained", 16'(q_slow.size()), 16'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule